// File: doc/BRIEF.md
# Tagged Receive Queue for Four Serial Lines

This block collects received characters from four serial lines into one shared queue of 64 words, 16 bits each. Software drains it through one read port. Each line has its own push port, which carries a character and three error flags. The block wraps every push into a tagged word. The word holds a valid flag, the error flags, the number of the line it came from and the character. Software can therefore service all four lines from a single read location and still tell which line each character came from.

A push is first captured in a one-word holding slot for its line. Each cycle, the lowest-numbered occupied slot moves into the queue. This lets several lines push in the same cycle without losing characters. The head of the queue is always visible on `rd_data`, and the `pop` strobe removes it. A receive-done flag tells software that the queue has something in it. A master-clear input discards everything the block holds.

Top module: `rx_tag_silo`

## Requirements
- R1: A queue word has this layout. Bit 15 is 1 (valid). Bit 14 is overrun, bit 13 is framing error and bit 12 is parity error. Bits 11:10 are 0. Bits 9:8 are the line number. Bits 7:0 are the character. For line i, `push_err[3i+2]` is overrun, `push_err[3i+1]` is framing and `push_err[3i]` is parity.
- R2: Words leave the queue in the order they entered it. The read and write positions wrap from 63 back to 0.
- R3: A push sampled at clock edge n shows on `rd_data` after edge n+1, provided the queue was empty and no other line has a word waiting in its slot.
- R4: Every word that moves out of a holding slot sets `rx_done`, whether the queue stores it or discards it.
- R5: A word that reaches the queue while the queue holds 64 words is discarded. The 64 stored words are left unchanged.
- R6: While the queue is empty, `rd_data` reads 0. A `pop` while the queue is empty leaves `rx_done` at 0.
- R7: A `pop` that removes the last word clears `rx_done`, unless a new word enters the queue in the same cycle.
- R8: When several lines push in the same cycle, their words enter the queue one per cycle, lowest line number first.
- R9: A push on a line whose holding slot still holds a word that does not leave this cycle is dropped. The held word gets its overrun bit (bit 14) set.
- R10: A `pop` and a word entering the queue in the same cycle both take effect, and the number of stored words stays the same.
- R11: `mclr` empties the queue, the holding slots and `rx_done` at the next edge.
- R12: `rd_data` shows the head word without removing it. Only `pop` advances the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclr | input | 1 | Master clear, synchronous |
| push_req | input | 4 | Push strobe, one bit per line |
| push_char | input | 32 | Characters, 8 bits per line (line i at bits 8i+7:8i) |
| push_err | input | 12 | Error flags, 3 bits per line |
| pop | input | 1 | Remove the head word |
| rd_data | output | 16 | Head word, or 0 when the queue is empty |
| rx_done | output | 1 | Queue holds at least one word |

## Verification
A wrong count or pointer shows up on `rd_data` within one pop. If the count is wrong, the bench sees a zero where a word was expected, or a stale word where zero was expected, once the queue should be empty. If a pointer is wrong, a word appears out of order. If the holding-slot arbitration is wrong, words from simultaneous pushes come out in the wrong line order, or come out without the overrun mark, two to four cycles after the push. A bad full check only shows after the queue has been drained: the last of the 64 reads returns the wrong character, or the read after it is not zero.

// File: rtl/rx_tag_silo.sv
module rx_tag_silo #(
  parameter int NLINES = 4,
  parameter int DEPTH  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mclr,
  input  logic [NLINES-1:0]   push_req,
  input  logic [NLINES*8-1:0] push_char,
  input  logic [NLINES*3-1:0] push_err,
  input  logic                pop,
  output logic [15:0]         rd_data,
  output logic                rx_done
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [15:0]       mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count_q;
  logic [15:0]       pend_word [NLINES];
  logic [NLINES-1:0] pend_vld;
  logic [1:0]        sel;
  logic              any_pend, full, wr, rd;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    sel = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (pend_vld[i]) sel = 2'(i);
  end

  assign any_pend = |pend_vld;
  assign full     = count_q == CW'(DEPTH);
  assign wr       = any_pend && !full;
  assign rd       = pop && count_q != '0;
  assign rd_data  = (count_q == '0) ? 16'h0000 : mem[rd_ptr];

  for (genvar i = 0; i < NLINES; i++) begin : g_slot
    logic        drain;
    logic [15:0] word_in;
    assign drain   = any_pend && sel == 2'(i);
    assign word_in = {1'b1, push_err[3*i +: 3], 2'b00, 2'(i), push_char[8*i +: 8]};

    always_ff @(posedge clk) begin
      if (!rst_n || mclr) begin
        pend_vld[i]  <= 1'b0;
        pend_word[i] <= '0;
      end else if (push_req[i]) begin
        if (pend_vld[i] && !drain) begin
          pend_word[i][14] <= 1'b1;
        end else begin
          pend_vld[i]  <= 1'b1;
          pend_word[i] <= word_in;
        end
      end else if (drain) begin
        pend_vld[i] <= 1'b0;
      end
    end

    // R9
    slot_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mclr && push_req[i] && pend_vld[i] && !drain) |=> (pend_vld[i] && pend_word[i][14]));
  end

  always_ff @(posedge clk)
    if (wr) mem[wr_ptr] <= pend_word[sel];

  always_ff @(posedge clk) begin
    if (!rst_n || mclr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      rx_done <= 1'b0;
    end else begin
      if (wr) wr_ptr <= bump(wr_ptr);
      if (rd) rd_ptr <= bump(rd_ptr);
      if (wr && !rd)      count_q <= count_q + 1'b1;
      else if (rd && !wr) count_q <= count_q - 1'b1;
      if (any_pend)
        rx_done <= 1'b1;
      else if (pop && count_q <= CW'(1))
        rx_done <= 1'b0;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R4
  push_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclr && any_pend) |=> rx_done);
  // R7
  last_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclr && pop && count_q == CW'(1) && !any_pend) |=> (!rx_done && rd_data == 16'h0000));
  // R10
  rd_wr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclr && wr && rd) |=> $stable(count_q));
  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (count_q == '0 && !rx_done && pend_vld == '0));
  // R8
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld[0] |-> sel == 2'd0);
endmodule

// File: tb/rx_tag_silo_test.sv
module rx_tag_silo_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mclr = 0;
  logic [3:0]  push_req = '0;
  logic [31:0] push_char = '0;
  logic [11:0] push_err = '0;
  logic        pop = 0;
  logic [15:0] rd_data;
  logic        rx_done;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  rx_tag_silo uut (.clk, .rst_n, .mclr, .push_req, .push_char, .push_err,
                   .pop, .rd_data, .rx_done);

  always #5 clk = ~clk;

  // {line[1:0], err[2:0] = overrun/framing/parity, char[7:0]}
  localparam logic [12:0] VEC [8] = '{
    {2'd0, 3'b000, 8'h41}, {2'd1, 3'b001, 8'h5a}, {2'd2, 3'b010, 8'h00},
    {2'd3, 3'b100, 8'hff}, {2'd3, 3'b111, 8'h7e}, {2'd1, 3'b000, 8'h0d},
    {2'd0, 3'b011, 8'ha5}, {2'd2, 3'b101, 8'h33}};

  function automatic logic [15:0] mk(input logic [1:0] ln, input logic [2:0] e,
                                     input logic [7:0] c);
    return {1'b1, e, 2'b00, ln, c};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push1(input logic [1:0] ln, input logic [2:0] e, input logic [7:0] c);
    push_req = '0;
    push_req[ln] = 1'b1;
    push_char[8*ln +: 8] = c;
    push_err[3*ln +: 3] = e;
    cyc(1);
    push_req = '0;
  endtask

  task automatic read_chk(input string req, input logic [15:0] exp);
    check(req, rd_data, exp);
    pop = 1'b1;
    cyc(1);
    pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    check("R6 reset data", rd_data, 16'h0);
    check("R11 reset done", {15'd0, rx_done}, 16'h0);

    // R3 two-edge latency
    push1(2'd2, 3'b000, 8'h61);
    check("R3 not yet", rd_data, 16'h0);
    cyc(1);
    check("R3 visible", rd_data, mk(2'd2, 3'b000, 8'h61));
    check("R4 done", {15'd0, rx_done}, 16'h1);
    cyc(2);
    check("R12 no pop keeps head", rd_data, mk(2'd2, 3'b000, 8'h61));
    read_chk("R12 head", mk(2'd2, 3'b000, 8'h61));
    check("R7 last read clears", {15'd0, rx_done}, 16'h0);

    // table walk: R1 layout, R2 order
    foreach (VEC[k]) push1(VEC[k][12:11], VEC[k][10:8], VEC[k][7:0]);
    cyc(2);
    check("R4 done after table", {15'd0, rx_done}, 16'h1);
    foreach (VEC[k]) read_chk("R1 R2 table word", mk(VEC[k][12:11], VEC[k][10:8], VEC[k][7:0]));
    check("R7 done cleared", {15'd0, rx_done}, 16'h0);
    read_chk("R6 empty read", 16'h0);
    check("R6 done stays low", {15'd0, rx_done}, 16'h0);

    // R8 all lines at once
    push_req = 4'hf;
    push_char = {8'hd3, 8'hc2, 8'hb1, 8'ha0};
    push_err = 12'b000_000_000_000;
    cyc(1);
    push_req = '0;
    cyc(5);
    for (int i = 0; i < 4; i++)
      read_chk("R8 priority order", mk(2'(i), 3'b000, 8'ha0 + 8'(i * 17)));
    check("R8 drained", rd_data, 16'h0);

    // R9 slot collision
    push_req = 4'b0101;
    push_char = {8'h00, 8'h41, 8'h00, 8'h11};
    push_err = '0;
    cyc(1);
    push_req = 4'b0100;
    push_char[23:16] = 8'h42;
    cyc(1);
    push_req = '0;
    cyc(2);
    read_chk("R9 line0 word", 16'h8011);
    read_chk("R9 held word gets overrun", 16'hc241);
    check("R9 second char dropped", rd_data, 16'h0);

    // R10 simultaneous read and write
    push1(2'd3, 3'b000, 8'h33);
    cyc(1);
    check("R10 first word", rd_data, 16'h8333);
    push1(2'd3, 3'b000, 8'h34);
    pop = 1'b1;
    cyc(1);
    pop = 1'b0;
    check("R10 new head", rd_data, 16'h8334);
    check("R10 done held", {15'd0, rx_done}, 16'h1);
    read_chk("R10 single word", 16'h8334);
    check("R10 empty after", rd_data, 16'h0);

    // R5 fill beyond depth, R2 wrap
    for (int k = 0; k < 70; k++) begin
      push_req = 4'b0010;
      push_char[15:8] = 8'(k);
      push_err[5:3] = 3'b000;
      cyc(1);
    end
    push_req = '0;
    cyc(2);
    check("R4 done when full", {15'd0, rx_done}, 16'h1);
    for (int k = 0; k < 64; k++) read_chk("R5 R2 stored word", mk(2'd1, 3'b000, 8'(k)));
    check("R5 excess discarded", rd_data, 16'h0);
    check("R7 done after drain", {15'd0, rx_done}, 16'h0);

    // R11 master clear with pending slots
    push_req = 4'b0011;
    push_char = 32'h0000_2221;
    cyc(1);
    push_req = '0;
    cyc(3);
    push1(2'd2, 3'b000, 8'h55);
    mclr = 1'b1;
    cyc(1);
    mclr = 1'b0;
    check("R11 data cleared", rd_data, 16'h0);
    check("R11 done cleared", {15'd0, rx_done}, 16'h0);
    cyc(3);
    check("R11 slots cleared", rd_data, 16'h0);
    check("R11 done stays low", {15'd0, rx_done}, 16'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule